// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block keeps the two interrupt status words of a storage-card host controller. One word holds the normal events: command complete, transfer complete, DMA complete, FIFO ready and card interrupt. The other holds the error events. The command and data engines send one-cycle event pulses. A pulse sets its status bit only when the matching bit of that word's latch mask is 1.

Software reads the status words through a 16-bit register port and clears bits by writing ones to them. Bit 15 of the normal word is not stored. It reads as the OR of every latched error bit, so a single read shows whether any error is pending. Two output-enable words choose which latched bits drive the level interrupt line. The line is registered.

The register offsets are byte addresses on an 8-bit address bus:

| Offset | Register |
|---|---|
| 0x60 | normal status |
| 0x64 | error status |
| 0x68 | normal latch mask |
| 0x6C | error latch mask |
| 0x70 | normal output enable |
| 0x74 | error output enable |

Top module: `irq_status_ctl`

## Requirements
- R1: A normal event pulse on a bit whose normal latch mask bit is 1 sets that bit of the normal status word at the same clock edge. The implemented bits are 0 to 5, 8, 10 and 11: command done, data done, block gap, DMA done, write ready, read ready, card interrupt, eight-word read ready and eight-word write ready.
- R2: An error event pulse on a bit whose error latch mask bit is 1 sets that bit of the error status word at the same clock edge. The implemented bits are 0 to 6 and 8 to 14.
- R3: An event on a bit whose latch mask bit is 0 never sets that status bit. This covers, for example, a data timeout (error bit 4) while it is masked.
- R4: A write to a status word clears every bit written as 1 and leaves the bits written as 0 unchanged. Writing 0xFFFF empties the word.
- R5: If an event and a write-1 clear reach the same status bit in the same cycle, the bit stays set.
- R6: Bit 15 of the normal status word reads as the OR of all latched error bits. Writing 1 to it has no effect, and it reads 0 once every error bit has been cleared.
- R7: The interrupt output is registered. In each cycle it equals the value, from the previous cycle, of the OR of (normal status read value AND normal enable) with (error status AND error enable).
- R8: Writing zero to both enable words drops the interrupt output one cycle later. The latched status is kept.
- R9: Status bits outside the implemented sets always read 0, even when events arrive on them with the mask set.
- R10: After reset every register reads 0 and the interrupt output is 0. The mask and enable words read back the last value written. Offsets other than the six listed read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset, used for both reads and writes |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| norm_evt | input | 16 | Normal event pulses, bit-aligned with the normal status word |
| err_evt | input | 16 | Error event pulses, bit-aligned with the error status word |
| irq | output | 1 | Level interrupt output, registered |

## Verification
Events and writes take effect at a rising clock edge. `rdata` shows the new status during the cycle that follows that edge, because the read path is combinational from the registers. The interrupt line reflects the new status one edge later again.

The bench keeps a cycle model that is updated at each rising edge. It computes the expected interrupt from the model state as it stood before the edge, so the interrupt check always lags the status by exactly one cycle. Inputs change on the falling edge, and `rdata` and `irq` are sampled 1 ns after it. Each sample therefore compares against the state written by the preceding rising edge.

// File: rtl/irq_status_ctl.sv
module irq_status_ctl #(
  parameter int AW = 8,
  parameter logic [AW-1:0] OFS_NST  = 8'h60,
  parameter logic [AW-1:0] OFS_EST  = 8'h64,
  parameter logic [AW-1:0] OFS_NMSK = 8'h68,
  parameter logic [AW-1:0] OFS_EMSK = 8'h6C,
  parameter logic [AW-1:0] OFS_NEN  = 8'h70,
  parameter logic [AW-1:0] OFS_EEN  = 8'h74
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  output logic [15:0]   rdata,
  input  logic [15:0]   norm_evt,
  input  logic [15:0]   err_evt,
  output logic          irq
);
  localparam logic [15:0] NORM_IMPL = 16'h0D3F;
  localparam logic [15:0] ERR_IMPL  = 16'h7F7F;

  logic [15:0] nst, est, nmsk, emsk, nen, een;
  logic [15:0] nview;

  wire hit_nst  = wr_en && (addr == OFS_NST);
  wire hit_est  = wr_en && (addr == OFS_EST);
  wire hit_nmsk = wr_en && (addr == OFS_NMSK);
  wire hit_emsk = wr_en && (addr == OFS_EMSK);
  wire hit_nen  = wr_en && (addr == OFS_NEN);
  wire hit_een  = wr_en && (addr == OFS_EEN);

  wire [15:0] nclr = hit_nst ? wdata : 16'h0;
  wire [15:0] eclr = hit_est ? wdata : 16'h0;

  assign nview = nst | {|est, 15'h0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nst  <= '0;
      est  <= '0;
      nmsk <= '0;
      emsk <= '0;
      nen  <= '0;
      een  <= '0;
      irq  <= 1'b0;
    end else begin
      nst <= ((nst & ~nclr) | (norm_evt & nmsk)) & NORM_IMPL;
      est <= ((est & ~eclr) | (err_evt & emsk)) & ERR_IMPL;
      if (hit_nmsk) nmsk <= wdata;
      if (hit_emsk) emsk <= wdata;
      if (hit_nen)  nen  <= wdata;
      if (hit_een)  een  <= wdata;
      irq <= (|(nview & nen)) | (|(est & een));
    end
  end

  always_comb begin
    case (addr)
      OFS_NST:  rdata = nview;
      OFS_EST:  rdata = est;
      OFS_NMSK: rdata = nmsk;
      OFS_EMSK: rdata = emsk;
      OFS_NEN:  rdata = nen;
      OFS_EEN:  rdata = een;
      default:  rdata = 16'h0;
    endcase
  end
endmodule

// File: rtl/irq_status_ctl_chk.sv
module irq_status_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [7:0]  addr,
  input logic [15:0] wdata,
  input logic [15:0] norm_evt,
  input logic [15:0] err_evt,
  input logic [15:0] nst,
  input logic [15:0] est,
  input logic [15:0] nmsk,
  input logic [15:0] emsk,
  input logic [15:0] nen,
  input logic [15:0] een,
  input logic        irq
);
  localparam logic [15:0] NORM_IMPL = 16'h0D3F;
  localparam logic [15:0] ERR_IMPL  = 16'h7F7F;

  // R1
  norm_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(norm_evt & nmsk & NORM_IMPL)) |=>
      ((nst & $past(norm_evt & nmsk & NORM_IMPL)) == $past(norm_evt & nmsk & NORM_IMPL)));

  // R2
  err_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(err_evt & emsk & ERR_IMPL)) |=>
      ((est & $past(err_evt & emsk & ERR_IMPL)) == $past(err_evt & emsk & ERR_IMPL)));

  // R3
  masked_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((est & ~$past(est)) & ~$past(err_evt & emsk)) == 16'h0) &&
             (((nst & ~$past(nst)) & ~$past(norm_evt & nmsk)) == 16'h0));

  // R4
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h60 && ((norm_evt & nmsk & wdata) == 16'h0)) |=>
      ((nst & $past(wdata) & NORM_IMPL) == 16'h0));

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h64 && |(err_evt & emsk & wdata & ERR_IMPL)) |=>
      ((est & $past(err_evt & emsk & wdata & ERR_IMPL)) == $past(err_evt & emsk & wdata & ERR_IMPL)));

  // R7
  irq_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past((|((nst | {|est, 15'h0}) & nen)) | (|(est & een)))));
endmodule

bind irq_status_ctl irq_status_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .norm_evt(norm_evt), .err_evt(err_evt), .nst(nst), .est(est),
  .nmsk(nmsk), .emsk(emsk), .nen(nen), .een(een), .irq(irq)
);

// File: tb/irq_status_ctl_bench.sv
`timescale 1ns/1ps
module irq_status_ctl_bench;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0] addr = 0;
  logic [15:0] wdata = 0, norm_evt = 0, err_evt = 0;
  logic [15:0] rdata;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [15:0] m_nst, m_est, m_nmsk, m_emsk, m_nen, m_een;
  logic m_irq;

  always #2 clk = ~clk;

  irq_status_ctl u_irq_status_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .norm_evt(norm_evt), .err_evt(err_evt), .irq(irq)
  );

  function automatic logic [15:0] exp_read(logic [7:0] a);
    case (a)
      8'h60: return m_nst | {(m_est != 0), 15'h0};
      8'h64: return m_est;
      8'h68: return m_nmsk;
      8'h6C: return m_emsk;
      8'h70: return m_nen;
      8'h74: return m_een;
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic exp_irq();
    return ((exp_read(8'h60) & m_nen) != 0) || ((m_est & m_een) != 0);
  endfunction

  task automatic model_reset();
    m_nst = 0; m_est = 0; m_nmsk = 0; m_emsk = 0; m_nen = 0; m_een = 0; m_irq = 0;
  endtask

  task automatic model_step();
    logic nirq;
    logic [15:0] nc, ec;
    nirq = exp_irq();
    nc = (wr_en && addr == 8'h60) ? wdata : 16'h0;
    ec = (wr_en && addr == 8'h64) ? wdata : 16'h0;
    m_nst = ((m_nst & ~nc) | (norm_evt & m_nmsk)) & 16'h0D3F;
    m_est = ((m_est & ~ec) | (err_evt & m_emsk)) & 16'h7F7F;
    if (wr_en && addr == 8'h68) m_nmsk = wdata;
    if (wr_en && addr == 8'h6C) m_emsk = wdata;
    if (wr_en && addr == 8'h70) m_nen = wdata;
    if (wr_en && addr == 8'h74) m_een = wdata;
    m_irq = nirq;
  endtask

  task automatic chk16(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, check pre-edge state, then advance.
  task automatic cyc(string req, logic w, logic [7:0] a, logic [15:0] d,
                     logic [15:0] ne, logic [15:0] ee);
    wr_en = w; addr = a; wdata = d; norm_evt = ne; err_evt = ee;
    #1;
    chk16(req, rdata, exp_read(a));
    chk16("R7 irq", {15'h0, irq}, {15'h0, m_irq});
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic rd(string req, logic [7:0] a);
    cyc(req, 1'b0, a, 16'h0, 16'h0, 16'h0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state and unknown offset
    rd("R10", 8'h60); rd("R10", 8'h64); rd("R10", 8'h68);
    rd("R10", 8'h70); rd("R10", 8'h44);
    // R3 events while masks are zero after reset
    cyc("R3", 0, 8'h60, 0, 16'hFFFF, 16'hFFFF);
    rd("R3", 8'h60); rd("R3", 8'h64);
    // R10 mask readback
    cyc("R10", 1, 8'h68, 16'hFFFF, 0, 0);
    cyc("R10", 1, 8'h6C, 16'hFFFF, 0, 0);
    rd("R10", 8'h68); rd("R10", 8'h6C);
    // R1 R9 all normal events, only implemented bits latch
    cyc("R1", 0, 8'h60, 0, 16'hFFFF, 0);
    rd("R1", 8'h60); rd("R9", 8'h60);
    // R2 R6 error events and summary bit
    cyc("R2", 0, 8'h64, 0, 0, 16'hFFFF);
    rd("R2", 8'h64); rd("R6", 8'h60);
    // R6 summary is read-only
    cyc("R6", 1, 8'h60, 16'h8000, 0, 0);
    rd("R6", 8'h60);
    // R4 clear a single bit
    cyc("R4", 1, 8'h60, 16'h0001, 0, 0);
    rd("R4", 8'h60);
    // R8 enables zero: no interrupt while status is pending
    rd("R8", 8'h70); rd("R8", 8'h60);
    // R7 enable data done, irq follows one cycle later
    cyc("R7", 1, 8'h70, 16'h0002, 0, 0);
    rd("R7", 8'h70); rd("R7", 8'h70);
    // R8 silence again, status kept
    cyc("R8", 1, 8'h70, 16'h0000, 0, 0);
    rd("R8", 8'h60); rd("R8", 8'h60);
    // R5 set beats clear on data timeout
    cyc("R5", 1, 8'h64, 16'h0010, 0, 16'h0010);
    rd("R5", 8'h64);
    // R4 R6 clear everything, summary drops
    cyc("R4", 1, 8'h64, 16'hFFFF, 0, 0);
    rd("R6", 8'h60);
    // R3 mask out data timeout
    cyc("R3", 1, 8'h6C, 16'hFFEF, 0, 0);
    cyc("R3", 0, 8'h64, 0, 0, 16'h0010);
    rd("R3", 8'h64);
    cyc("R4", 1, 8'h60, 16'hFFFF, 0, 0);
    rd("R4", 8'h60);
    // R7 error enable path
    cyc("R7", 1, 8'h74, 16'h0001, 0, 0);
    cyc("R7", 0, 8'h64, 0, 0, 16'h0001);
    rd("R7", 8'h64); rd("R7", 8'h64);

    // Random mix covering R1 R2 R3 R4 R5 R6 R7 R9 R10
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a;
      logic w;
      logic [15:0] d, ne, ee;
      case ($urandom_range(0, 6))
        0: a = 8'h60; 1: a = 8'h64; 2: a = 8'h68; 3: a = 8'h6C;
        4: a = 8'h70; 5: a = 8'h74; default: a = 8'h50;
      endcase
      w  = ($urandom_range(0, 3) == 0);
      d  = 16'($urandom);
      ne = ($urandom_range(0, 2) == 0) ? 16'($urandom) : 16'h0;
      ee = ($urandom_range(0, 4) == 0) ? 16'($urandom) : 16'h0;
      cyc("R1 R2 rand", w, a, d, ne, ee);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule